// File: doc/BRIEF.md
# Call Gate Privilege-Raise Stack Sequencer

This block carries out the stack work of a far call made through a call gate. When `start` is sampled, it first decides whether the call stays at the current privilege level or enters more-privileged code. It then checks that the destination stack has enough room. After that it streams the required words onto the destination stack, one write per cycle. On the privilege-raising path, the words are the caller's stack pointer, the parameters copied from the caller's stack through a read port, and the return address. On the same-level path, only the return address is pushed, onto the caller's own stack.

When the last write is done, the block loads the new code selector, offset and privilege level, and pulses `done`. If the stack is too small, the block raises a stack fault. In that case it issues no write and leaves every architectural output unchanged. Descriptor checks on the new stack selector and task switching are handled elsewhere.

Top module: `cgate_stack_seq`

## Requirements
- R1: The privilege-raising path is taken only when `tgt_conforming` is 0 and `tgt_dpl` < `cur_cpl`. Any other combination takes the same-level path, which writes only the return selector and then the return offset, onto the caller's stack starting at `old_esp`.
- R2: Only the low 5 bits of `gate_count` set the number of copied parameters N, which runs from 0 to 31. The upper bits have no effect on the writes or on the final stack pointer.
- R3: The room needed on the privilege-raising path is 4*N+16 bytes when `op32`=1 and 2*N+8 bytes when `op32`=0. On the same-level path it is 8 or 4 bytes. When `room` is smaller than this, `ss_fault` is high for exactly the one cycle after the start edge, no write is issued, and `ss_out`, `esp_out`, `cs_out`, `eip_out` and `cpl_out` keep their values.
- R4: Writes on the privilege-raising path begin in the cycle after the start edge and come one per cycle, in this order: old SS, old ESP, the N parameters, return CS, return EIP. Each write address equals the previous stack pointer minus the unit size (4 when `op32`=1, 2 otherwise). The first write uses `tss_esp` as the previous stack pointer.
- R5: Parameter k (k = 0 .. N-1) is read with `rd_en` high from `rd_addr` = `old_esp` + unit*(N-1-k). The value returned on `rd_data` in that same cycle is the value written.
- R6: With `op32`=1, `wr_wide` is 1 and selectors are zero-extended to 32 bits. With `op32`=0, `wr_wide` is 0 and `wr_data` carries only bits [15:0], with the upper 16 bits zero.
- R7: After a privilege-raising call, `ss_out`=`tss_ss`, `esp_out`=`tss_esp` - unit*(N+4) and `cpl_out`=`tgt_dpl`. After a same-level call, `ss_out`=`old_ss`, `esp_out`=`old_esp` - 2*unit and `cpl_out` is unchanged. In both cases `cs_out` is `gate_sel` with bits [1:0] replaced by the new `cpl_out`, and `eip_out` is `gate_off`, masked to 16 bits when `op32`=0.
- R8: `done` is high for exactly one cycle, the cycle after the last write. The final values of R7 are visible from that cycle on.
- R9: A `start` that arrives while `busy` is high is ignored.
- R10: After reset, `busy`, `done`, `ss_fault`, `wr_en` and `rd_en` are 0, and every architectural output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a gate call with the current inputs |
| tgt_dpl | input | 2 | Privilege level of the gate's target code segment |
| tgt_conforming | input | 1 | Target code segment is conforming |
| cur_cpl | input | 2 | Current privilege level |
| gate_count | input | 8 | Parameter count field of the gate |
| gate_sel | input | 16 | Code selector from the gate |
| gate_off | input | 32 | Entry offset from the gate |
| tss_ss | input | 16 | Inner stack selector from the task state segment |
| tss_esp | input | 32 | Inner stack pointer from the task state segment |
| old_ss | input | 16 | Caller's stack selector |
| old_esp | input | 32 | Caller's stack pointer |
| ret_cs | input | 16 | Return code selector |
| ret_eip | input | 32 | Return offset |
| op32 | input | 1 | 32-bit operand size |
| room | input | 32 | Free bytes on the destination stack |
| rd_en | output | 1 | Caller-stack read strobe |
| rd_addr | output | 32 | Caller-stack read offset |
| rd_data | input | 32 | Caller-stack read data, same cycle |
| wr_en | output | 1 | Destination-stack write strobe |
| wr_addr | output | 32 | Destination-stack write offset |
| wr_data | output | 32 | Destination-stack write data |
| wr_wide | output | 1 | Write is 4 bytes (else 2) |
| ss_out | output | 16 | Current stack selector |
| esp_out | output | 32 | Current stack pointer |
| cs_out | output | 16 | Current code selector |
| eip_out | output | 32 | Current instruction offset |
| cpl_out | output | 2 | Current privilege level |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished pulse |
| ss_fault | output | 1 | Stack room fault pulse |

## Verification
The start edge is the reference point for all timing checks. The fault pulse is due in the first cycle after that edge. Write k (counting from 1) is due in cycle k after it. `done` is due in cycle W+1, where W is 4+N on the privilege-raising path and 2 on the same-level path. The bench drives and samples on the falling edge and counts falling edges from the start edge, so each sample lands in the cycle where the registered state has just changed. A scoreboard queue holds the expected writes in order. The monitor pops one entry for each observed write, and the driver checks that the queue is empty once `done` is seen.

// File: rtl/cgs_pkg.sv
package cgs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_SS = 3'd1,
        ST_PUSH_SP = 3'd2,
        ST_COPY    = 3'd3,
        ST_PUSH_CS = 3'd4,
        ST_PUSH_IP = 3'd5
    } cgs_state_e;

endpackage

// File: rtl/cgs_route.sv
// Path choice and stack-room check for a gate call.
module cgs_route #(
    parameter int AW   = 32,
    parameter int GCW  = 8,
    parameter int PCW  = 5,
    parameter int CPLW = 2
) (
    input  logic [CPLW-1:0] tgt_dpl,
    input  logic            tgt_conforming,
    input  logic [CPLW-1:0] cur_cpl,
    input  logic [GCW-1:0]  gate_count,
    input  logic            op32,
    input  logic [AW-1:0]   room,
    output logic            raise,
    output logic [PCW-1:0]  nparm,
    output logic [AW-1:0]   need,
    output logic            fault
);
    localparam logic [GCW-1:0] CNT_MASK = GCW'((1 << PCW) - 1);

    logic [GCW-1:0] cnt_masked;
    logic [AW-1:0]  parm_bytes;

    always_comb begin
        cnt_masked = gate_count & CNT_MASK;
        nparm      = cnt_masked[PCW-1:0];
        raise      = !tgt_conforming && (tgt_dpl < cur_cpl);
        parm_bytes = op32 ? (AW'(cnt_masked) << 2) : (AW'(cnt_masked) << 1);
        if (raise) begin
            need = parm_bytes + (op32 ? AW'(16) : AW'(8));
        end else begin
            need = op32 ? AW'(8) : AW'(4);
        end
        fault = room < need;
    end

endmodule

// File: rtl/cgs_fmt.sv
// Narrows a stack word to the active operand size.
module cgs_fmt #(
    parameter int AW = 32
) (
    input  logic          wide,
    input  logic [AW-1:0] raw,
    output logic [AW-1:0] val
);
    localparam int HW = AW / 2;

    assign val = wide ? raw : {{(AW - HW){1'b0}}, raw[HW-1:0]};

endmodule

// File: rtl/cgate_stack_seq.sv
module cgate_stack_seq
    import cgs_pkg::*;
#(
    parameter int AW   = 32,
    parameter int SW   = 16,
    parameter int GCW  = 8,
    parameter int PCW  = 5,
    parameter int CPLW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [CPLW-1:0] tgt_dpl,
    input  logic            tgt_conforming,
    input  logic [CPLW-1:0] cur_cpl,
    input  logic [GCW-1:0]  gate_count,
    input  logic [SW-1:0]   gate_sel,
    input  logic [AW-1:0]   gate_off,
    input  logic [SW-1:0]   tss_ss,
    input  logic [AW-1:0]   tss_esp,
    input  logic [SW-1:0]   old_ss,
    input  logic [AW-1:0]   old_esp,
    input  logic [SW-1:0]   ret_cs,
    input  logic [AW-1:0]   ret_eip,
    input  logic            op32,
    input  logic [AW-1:0]   room,
    output logic            rd_en,
    output logic [AW-1:0]   rd_addr,
    input  logic [AW-1:0]   rd_data,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [AW-1:0]   wr_data,
    output logic            wr_wide,
    output logic [SW-1:0]   ss_out,
    output logic [AW-1:0]   esp_out,
    output logic [SW-1:0]   cs_out,
    output logic [AW-1:0]   eip_out,
    output logic [CPLW-1:0] cpl_out,
    output logic            busy,
    output logic            done,
    output logic            ss_fault
);
    localparam logic [SW-1:0] RPL_MASK = SW'((1 << CPLW) - 1);

    typedef struct packed {
        cgs_state_e      state;
        logic            op32;
        logic [PCW-1:0]  cnt;
        logic [AW-1:0]   src;
        logic [AW-1:0]   esp;
        logic [SW-1:0]   ss;
        logic [SW-1:0]   cs;
        logic [AW-1:0]   eip;
        logic [CPLW-1:0] cpl;
        logic [SW-1:0]   sv_ss;
        logic [AW-1:0]   sv_esp;
        logic [SW-1:0]   rcs;
        logic [AW-1:0]   reip;
        logic [SW-1:0]   ncs;
        logic [AW-1:0]   neip;
        logic [CPLW-1:0] ncpl;
        logic            done;
        logic            fault;
    } cgs_regs_t;

    cgs_regs_t q, d;

    logic            raise;
    logic [PCW-1:0]  nparm;
    logic [AW-1:0]   need;
    logic            room_fault;
    logic [AW-1:0]   gate_off_fmt;
    logic [AW-1:0]   wr_raw;
    logic [AW-1:0]   wr_fmt;
    logic [AW-1:0]   step_q;
    logic [AW-1:0]   step_in;
    logic [AW-1:0]   esp_dn;
    logic [AW-1:0]   src_init;
    logic [CPLW-1:0] cpl_next;
    logic            wr_en_c;
    logic            rd_en_c;

    cgs_route #(
        .AW   (AW),
        .GCW  (GCW),
        .PCW  (PCW),
        .CPLW (CPLW)
    ) u_route (
        .tgt_dpl        (tgt_dpl),
        .tgt_conforming (tgt_conforming),
        .cur_cpl        (cur_cpl),
        .gate_count     (gate_count),
        .op32           (op32),
        .room           (room),
        .raise          (raise),
        .nparm          (nparm),
        .need           (need),
        .fault          (room_fault)
    );

    cgs_fmt #(.AW(AW)) u_fmt_entry (
        .wide (op32),
        .raw  (gate_off),
        .val  (gate_off_fmt)
    );

    cgs_fmt #(.AW(AW)) u_fmt_push (
        .wide (q.op32),
        .raw  (wr_raw),
        .val  (wr_fmt)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.fault  = 1'b0;
        wr_en_c  = 1'b0;
        rd_en_c  = 1'b0;
        wr_raw   = '0;
        step_q   = q.op32 ? AW'(4) : AW'(2);
        step_in  = op32 ? AW'(4) : AW'(2);
        esp_dn   = q.esp - step_q;
        src_init = old_esp + (op32 ? (AW'(nparm) << 2) : (AW'(nparm) << 1)) - step_in;
        cpl_next = raise ? tgt_dpl : cur_cpl;

        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    if (room_fault) begin
                        d.fault = 1'b1;
                    end else begin
                        d.op32   = op32;
                        d.cnt    = nparm;
                        d.src    = src_init;
                        d.sv_ss  = old_ss;
                        d.sv_esp = old_esp;
                        d.rcs    = ret_cs;
                        d.reip   = ret_eip;
                        d.ncs    = (gate_sel & ~RPL_MASK) | SW'(cpl_next);
                        d.neip   = gate_off_fmt;
                        d.ncpl   = cpl_next;
                        if (raise) begin
                            d.ss    = tss_ss;
                            d.esp   = tss_esp;
                            d.state = ST_PUSH_SS;
                        end else begin
                            d.ss    = old_ss;
                            d.esp   = old_esp;
                            d.state = ST_PUSH_CS;
                        end
                    end
                end
            end
            ST_PUSH_SS: begin
                wr_en_c = 1'b1;
                wr_raw  = AW'(q.sv_ss);
                d.esp   = esp_dn;
                d.state = ST_PUSH_SP;
            end
            ST_PUSH_SP: begin
                wr_en_c = 1'b1;
                wr_raw  = q.sv_esp;
                d.esp   = esp_dn;
                d.state = (q.cnt != '0) ? ST_COPY : ST_PUSH_CS;
            end
            ST_COPY: begin
                wr_en_c = 1'b1;
                rd_en_c = 1'b1;
                wr_raw  = rd_data;
                d.esp   = esp_dn;
                d.src   = q.src - step_q;
                d.cnt   = q.cnt - PCW'(1);
                if (q.cnt == PCW'(1)) begin
                    d.state = ST_PUSH_CS;
                end
            end
            ST_PUSH_CS: begin
                wr_en_c = 1'b1;
                wr_raw  = AW'(q.rcs);
                d.esp   = esp_dn;
                d.state = ST_PUSH_IP;
            end
            ST_PUSH_IP: begin
                wr_en_c = 1'b1;
                wr_raw  = q.reip;
                d.esp   = esp_dn;
                d.cs    = q.ncs;
                d.eip   = q.neip;
                d.cpl   = q.ncpl;
                d.done  = 1'b1;
                d.state = ST_IDLE;
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_en    = rd_en_c;
    assign rd_addr  = q.src;
    assign wr_en    = wr_en_c;
    assign wr_addr  = esp_dn;
    assign wr_data  = wr_fmt;
    assign wr_wide  = wr_en_c & q.op32;
    assign ss_out   = q.ss;
    assign esp_out  = q.esp;
    assign cs_out   = q.cs;
    assign eip_out  = q.eip;
    assign cpl_out  = q.cpl;
    assign busy     = (q.state != ST_IDLE);
    assign done     = q.done;
    assign ss_fault = q.fault;

endmodule

// File: rtl/cgs_checker.sv
module cgs_checker #(
    parameter int AW   = 32,
    parameter int SW   = 16,
    parameter int CPLW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [AW-1:0]   wr_addr,
    input logic            wr_wide,
    input logic            rd_en,
    input logic            busy,
    input logic            done,
    input logic            ss_fault,
    input logic [SW-1:0]   cs_out,
    input logic [CPLW-1:0] cpl_out
);

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ss_fault |-> (!wr_en && !busy)); // R3

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) - (wr_wide ? AW'(4) : AW'(2)))); // R4

    AST_READ_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> wr_en); // R5

    AST_RPL_TRACKS_CPL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_out[CPLW-1:0] == cpl_out)); // R7

    AST_DONE_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_en) && !wr_en && !busy)); // R8

    AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy); // R9

endmodule

bind cgate_stack_seq cgs_checker #(
    .AW   (AW),
    .SW   (SW),
    .CPLW (CPLW)
) u_cgs_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_wide  (wr_wide),
    .rd_en    (rd_en),
    .busy     (busy),
    .done     (done),
    .ss_fault (ss_fault),
    .cs_out   (cs_out),
    .cpl_out  (cpl_out)
);

// File: tb/cgate_stack_seq_bench.sv
`timescale 1ns/1ps
module cgate_stack_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  tgt_dpl = '0;
    logic        tgt_conforming = 1'b0;
    logic [1:0]  cur_cpl = '0;
    logic [7:0]  gate_count = '0;
    logic [15:0] gate_sel = '0;
    logic [31:0] gate_off = '0;
    logic [15:0] tss_ss = '0;
    logic [31:0] tss_esp = '0;
    logic [15:0] old_ss = '0;
    logic [31:0] old_esp = '0;
    logic [15:0] ret_cs = '0;
    logic [31:0] ret_eip = '0;
    logic        op32 = 1'b0;
    logic [31:0] room = '0;
    logic        rd_en;
    logic [31:0] rd_addr;
    logic [31:0] rd_data;
    logic        wr_en;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic        wr_wide;
    logic [15:0] ss_out;
    logic [31:0] esp_out;
    logic [15:0] cs_out;
    logic [31:0] eip_out;
    logic [1:0]  cpl_out;
    logic        busy;
    logic        done;
    logic        ss_fault;

    always #2.5 clk = ~clk;

    cgate_stack_seq u_cgate_stack_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .tgt_dpl(tgt_dpl), .tgt_conforming(tgt_conforming), .cur_cpl(cur_cpl),
        .gate_count(gate_count), .gate_sel(gate_sel), .gate_off(gate_off),
        .tss_ss(tss_ss), .tss_esp(tss_esp), .old_ss(old_ss), .old_esp(old_esp),
        .ret_cs(ret_cs), .ret_eip(ret_eip), .op32(op32), .room(room),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_wide(wr_wide),
        .ss_out(ss_out), .esp_out(esp_out), .cs_out(cs_out), .eip_out(eip_out),
        .cpl_out(cpl_out), .busy(busy), .done(done), .ss_fault(ss_fault)
    );

    // caller-stack model: content is a function of the address
    function automatic logic [31:0] stack_word(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3C3, ~a[15:0]};
    endfunction
    assign rd_data = stack_word(rd_addr);

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] d;
        logic        w;
    } item_t;

    item_t exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // monitor: pop one expected write per observed write
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4", "unexpected write addr", wr_addr, 32'h0);
            end else begin
                item_t it;
                string tg;
                it = exp_q.pop_front();
                tg = tag_q.pop_front();
                chk(wr_addr == it.a, tg, "write addr", wr_addr, it.a);
                chk(wr_data == it.d, tg, "write data", wr_data, it.d);
                chk(wr_wide == it.w, "R6", "write width", 32'(wr_wide), 32'(it.w));
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(1'b0, "R8", "watchdog expired", 32'(cycles), 32'h0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [31:0] narrow(input logic w, input logic [31:0] v);
        return w ? v : {16'h0, v[15:0]};
    endfunction

    task automatic push_exp(input logic [31:0] a, input logic [31:0] d, input logic w, input string tg);
        item_t it;
        it.a = a; it.d = d; it.w = w;
        exp_q.push_back(it);
        tag_q.push_back(tg);
    endtask

    // driver: compute expectations, fire start, check timing and final state
    task automatic run_call(input logic [1:0] dpl, input logic conf, input logic [1:0] cpl,
                            input logic [7:0] cnt, input logic w32, input logic [31:0] rm,
                            input bit poke_busy);
        bit          raise;
        int          n;
        int          unit;
        int          nw;
        int          cyc;
        logic [31:0] need;
        logic [31:0] esp;
        logic [15:0] p_ss, p_cs;
        logic [31:0] p_esp, p_eip;
        logic [1:0]  p_cpl;
        logic [31:0] x_esp, x_eip;
        logic [15:0] x_ss, x_cs;
        logic [1:0]  x_cpl;

        raise = !conf && (dpl < cpl);
        n     = int'(cnt & 8'h1F);
        unit  = w32 ? 4 : 2;
        need  = raise ? 32'(unit * n + (w32 ? 16 : 8)) : (w32 ? 32'd8 : 32'd4);
        p_ss = ss_out; p_esp = esp_out; p_cs = cs_out; p_eip = eip_out; p_cpl = cpl_out;

        tgt_dpl = dpl; tgt_conforming = conf; cur_cpl = cpl; gate_count = cnt;
        op32 = w32; room = rm;

        if (rm >= need) begin
            if (raise) begin
                esp = tss_esp;
                esp -= 32'(unit); push_exp(esp, 32'(old_ss), w32, "R4 old SS");
                esp -= 32'(unit); push_exp(esp, narrow(w32, old_esp), w32, "R4 old ESP");
                for (int k = 0; k < n; k++) begin
                    esp -= 32'(unit);
                    push_exp(esp, narrow(w32, stack_word(old_esp + 32'(unit * (n - 1 - k)))), w32,
                             "R5 parameter");
                end
                nw = 4 + n;
                x_ss = tss_ss; x_cpl = dpl;
            end else begin
                esp = old_esp;
                nw = 2;
                x_ss = old_ss; x_cpl = cpl;
            end
            esp -= 32'(unit); push_exp(esp, 32'(ret_cs), w32, "R1 return CS");
            esp -= 32'(unit); push_exp(esp, narrow(w32, ret_eip), w32, "R1 return EIP");
            x_esp = esp;
            x_cs  = {gate_sel[15:2], x_cpl};
            x_eip = narrow(w32, gate_off);
        end

        start = 1'b1;
        @(negedge clk);
        start = 1'b0;

        if (rm < need) begin
            chk(ss_fault == 1'b1, "R3", "fault pulse", 32'(ss_fault), 32'h1);
            chk(busy == 1'b0, "R3", "busy after fault", 32'(busy), 32'h0);
            @(negedge clk);
            chk(ss_fault == 1'b0, "R3", "fault pulse width", 32'(ss_fault), 32'h0);
            repeat (3) @(negedge clk);
            chk(esp_out == p_esp, "R3", "esp unchanged", esp_out, p_esp);
            chk(ss_out == p_ss, "R3", "ss unchanged", 32'(ss_out), 32'(p_ss));
            chk(cs_out == p_cs && eip_out == p_eip && cpl_out == p_cpl, "R3",
                "cs/eip/cpl unchanged", eip_out, p_eip);
        end else begin
            cyc = 1;
            chk(ss_fault == 1'b0, "R3", "no fault", 32'(ss_fault), 32'h0);
            if (poke_busy) begin
                // second start with a different gate while busy: must be ignored
                gate_count = 8'h03; tgt_conforming = 1'b1; op32 = ~w32; room = 32'h0;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                cyc++;
                chk(ss_fault == 1'b0, "R9", "no fault from ignored start", 32'(ss_fault), 32'h0);
            end
            while (!done && cyc < 100) begin
                @(negedge clk);
                cyc++;
            end
            chk(cyc == nw + 1, "R8", "done cycle", 32'(cyc), 32'(nw + 1));
            chk(exp_q.size() == 0, "R4", "all writes seen", 32'(exp_q.size()), 32'h0);
            chk(ss_out == x_ss, "R7", "ss", 32'(ss_out), 32'(x_ss));
            chk(esp_out == x_esp, "R7", "esp", esp_out, x_esp);
            chk(cs_out == x_cs, "R7", "cs", 32'(cs_out), 32'(x_cs));
            chk(eip_out == x_eip, "R7", "eip", eip_out, x_eip);
            chk(cpl_out == x_cpl, "R1", "cpl", 32'(cpl_out), 32'(x_cpl));
            @(negedge clk);
            chk(done == 1'b0, "R8", "done width", 32'(done), 32'h0);
            chk(busy == 1'b0 && wr_en == 1'b0, "R9", "idle after done", 32'(busy), 32'h0);
        end
        exp_q.delete();
        tag_q.delete();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset values
        chk(busy == 0 && done == 0 && ss_fault == 0, "R10", "status at reset", 32'({busy, done, ss_fault}), 32'h0);
        chk(wr_en == 0 && rd_en == 0, "R10", "strobes at reset", 32'({wr_en, rd_en}), 32'h0);
        chk(esp_out == 0 && eip_out == 0 && ss_out == 0 && cs_out == 0 && cpl_out == 0,
            "R10", "state at reset", esp_out, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        gate_sel = 16'h0048; gate_off = 32'h1234_5678;
        tss_ss = 16'h0010; tss_esp = 32'h0000_8000;
        old_ss = 16'h002B; old_esp = 32'h0000_4F00;
        ret_cs = 16'h0033; ret_eip = 32'hABCD_0102;

        // R1/R4/R5/R6: raise path, 32-bit, three parameters
        run_call(2'd0, 1'b0, 2'd3, 8'd3, 1'b1, 32'h100, 1'b0);
        // R2: upper count bits ignored, 16-bit size
        old_esp = 32'h0000_3A10; tss_esp = 32'h0000_7000; gate_sel = 16'h005B;
        run_call(2'd1, 1'b0, 2'd3, 8'hE2, 1'b0, 32'h100, 1'b0);
        // raise path with no parameters
        run_call(2'd2, 1'b0, 2'd3, 8'd0, 1'b1, 32'h10, 1'b0);
        // R1: conforming target stays at the same level
        old_esp = 32'h0000_2200;
        run_call(2'd0, 1'b1, 2'd3, 8'd4, 1'b1, 32'h8, 1'b0);
        // R1: equal privilege, 16-bit, same level
        run_call(2'd2, 1'b0, 2'd2, 8'd6, 1'b0, 32'h4, 1'b0);
        // R3: room exactly sufficient, then one byte short
        tss_esp = 32'h0000_9000;
        run_call(2'd0, 1'b0, 2'd2, 8'd4, 1'b1, 32'd32, 1'b0);
        run_call(2'd0, 1'b0, 2'd2, 8'd4, 1'b1, 32'd31, 1'b0);
        // R3: same-level fault on a 16-bit call
        run_call(2'd3, 1'b0, 2'd3, 8'd0, 1'b0, 32'd3, 1'b0);
        // R9: start during a sequence is ignored
        old_esp = 32'h0000_5000; ret_eip = 32'h0000_7777;
        run_call(2'd1, 1'b0, 2'd2, 8'd5, 1'b1, 32'h100, 1'b1);
        // R2: full 31-parameter copy, 16-bit
        old_esp = 32'h0000_6000; tss_esp = 32'h0000_A000;
        run_call(2'd0, 1'b0, 2'd1, 8'hFF, 1'b0, 32'h100, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule